// File: doc/BRIEF.md
# ATA PIO Host Cycle Sequencer

This block runs one programmed-I/O transfer on a parallel ATA bus at a time, from the host side. A request carries the direction, the transfer width (8-bit register access or 16-bit data access), the register address, the chip-select choice and, for writes, the data word. The sequencer then drives the address and chip selects, waits the setup count, pulses the read or write strobe, holds the address and write data after the strobe, and waits out recovery and the minimum total cycle time before it reports completion.

Every interval is a count of system clock cycles taken from timing inputs that software programs. The counts are captured when a request is accepted, so a transfer always runs with one consistent set. The device's ready line is synchronised and sampled a programmed number of cycles before the strobe would end. While it is low the strobe is held. A timeout count stops a stuck ready line from hanging the bus. In that case the strobe is released and the transfer ends with an error flag.

Top module: `pio_cycle_seq`

## Requirements
- R1: After reset `ready` is 1, `done` and `done_err` are 0, both strobes and both chip selects are high (inactive), and `ata_dd_oe` is 0.
- R2: A transfer asserts the selected chip select (select 0 drives `ata_cs_n` to 2'b10, select 1 drives 2'b01) and the address. The strobe goes low after exactly max(`tm_setup`,1) cycles. The address and chip select do not change while the strobe is low.
- R3: With the ready line high, a 16-bit transfer holds its strobe low for exactly max(`tm_width16`,1) cycles.
- R4: An 8-bit transfer holds its strobe low for max(`tm_width8`,1) cycles. An 8-bit read returns the low byte of the bus with the upper bits of `rd_data` zero.
- R5: After the strobe rises, the chip select and address stay valid for exactly max(`tm_hold`,1) cycles.
- R6: The number of cycles with `ready` low equals the larger of `tm_cycle` and setup + strobe + hold + max(`tm_recov`,1), where each count below 1 is taken as 1.
- R7: In a write, `ata_dd_oe` is 1 and `ata_dd_out` equals the write word in every cycle that the chip select is active. `ata_dd_oe` is never 1 in a read, and the two strobes are never low together.
- R8: A read returns in `rd_data` the value on `ata_dd_in` in the last cycle of the strobe.
- R9: If the ready line is low at the sample point (`tm_rdy_setup` cycles before the strobe would end, clamped to the strobe length), the strobe is extended while it stays low, and `done_err` stays 0.
- R10: If the ready line stays low, the strobe is extended by exactly `tm_rdy_tmo` cycles and then released. The transfer still completes its hold and recovery, and `done_err` is 1 with `done`.
- R11: A request is taken only while `ready` is 1. A request raised while busy is ignored, and timing inputs changed during a transfer do not affect it.
- R12: `done` is a one-cycle pulse, issued in the first cycle that `ready` is 1 again, with `rd_data` and `done_err` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Transfer request, taken when `ready` is 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit transfer, 0 = 8-bit |
| req_addr | input | AW | Register address |
| req_cs_sel | input | 1 | Chip select to use (0 or 1) |
| req_wdata | input | DW | Write data |
| tm_setup | input | CW | Address setup cycles |
| tm_width16 | input | CW | Strobe width for 16-bit transfers |
| tm_width8 | input | CW | Strobe width for 8-bit transfers |
| tm_hold | input | CW | Address/data hold cycles after the strobe |
| tm_recov | input | CW | Recovery cycles after hold |
| tm_cycle | input | CW | Minimum total busy cycles |
| tm_rdy_setup | input | CW | Ready-line sample point before strobe end |
| tm_rdy_tmo | input | CW | Maximum extension cycles for ready low |
| ready | output | 1 | Sequencer idle, request can be taken |
| done | output | 1 | Transfer complete pulse |
| done_err | output | 1 | Ready-line timeout occurred (valid with `done`) |
| rd_data | output | DW | Captured read data |
| ata_addr | output | AW | Bus address lines |
| ata_cs_n | output | 2 | Active-low chip selects |
| ata_rd_n | output | 1 | Active-low read strobe |
| ata_wr_n | output | 1 | Active-low write strobe |
| ata_dd_out | output | DW | Data bus output value |
| ata_dd_oe | output | 1 | Data bus output enable |
| ata_dd_in | input | DW | Data bus input value |
| ata_iordy | input | 1 | Device ready line |

## Verification
A wrong phase counter or a wrong next-state choice shows up as a strobe, setup or hold length that is off by one or more cycles. The scoreboard sees this on the very transfer where it happens, because it measures each interval at the bus pins. A wrong latch of the timing inputs or of the request fields appears as a wrong width, address or data word on the transfer that follows the stimulus. A wrong stall or timeout count shows as a strobe of the wrong length and a wrong `done_err` when that transfer completes. Bus contention or a stray strobe would be visible in the same cycle it occurs.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_SETUP  = 3'd1,
      ST_STROBE = 3'd2,
      ST_HOLD   = 3'd3,
      ST_RECOV  = 3'd4
   } pio_state_e;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 0 || STAGES > 4) begin : g_bad
      $error("pio_sync: STAGES must be 0..4");
   end

   if (STAGES == 0) begin : g_pass
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sr <= {STAGES{RST_VAL}};
         end else begin
            sr[0] <= d;
            for (int i = 1; i < STAGES; i++) sr[i] <= sr[i-1];
         end
      end
      assign q = sr[STAGES-1];
   end
endmodule

// File: rtl/pio_down_cnt.sv
module pio_down_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic [W-1:0] cnt,
   output logic         zero
);
   if (W < 2) begin : g_bad
      $error("pio_down_cnt: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (load) cnt <= load_val;
      else if (dec)  cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

   // R6: a phase counter is never decremented past zero
   p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load) |-> (cnt != '0));
endmodule

// File: rtl/pio_cycle_seq.sv
module pio_cycle_seq
   import pio_seq_pkg::*;
#(
   parameter int AW          = 3,
   parameter int DW          = 16,
   parameter int CW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic          req_write,
   input  logic          req_wide,
   input  logic [AW-1:0] req_addr,
   input  logic          req_cs_sel,
   input  logic [DW-1:0] req_wdata,
   input  logic [CW-1:0] tm_setup,
   input  logic [CW-1:0] tm_width16,
   input  logic [CW-1:0] tm_width8,
   input  logic [CW-1:0] tm_hold,
   input  logic [CW-1:0] tm_recov,
   input  logic [CW-1:0] tm_cycle,
   input  logic [CW-1:0] tm_rdy_setup,
   input  logic [CW-1:0] tm_rdy_tmo,
   output logic          ready,
   output logic          done,
   output logic          done_err,
   output logic [DW-1:0] rd_data,
   output logic [AW-1:0] ata_addr,
   output logic [1:0]    ata_cs_n,
   output logic          ata_rd_n,
   output logic          ata_wr_n,
   output logic [DW-1:0] ata_dd_out,
   output logic          ata_dd_oe,
   input  logic [DW-1:0] ata_dd_in,
   input  logic          ata_iordy
);
   localparam int BYTE_W = 8;
   localparam int UPPER_W = DW - BYTE_W;
   localparam logic [CW-1:0] CNT_ONE = {{(CW-1){1'b0}}, 1'b1};
   localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

   if (AW < 1) begin : g_bad_aw
      $error("pio_cycle_seq: AW must be at least 1");
   end
   if (DW <= BYTE_W || (DW % BYTE_W) != 0) begin : g_bad_dw
      $error("pio_cycle_seq: DW must be a multiple of 8 above 8");
   end
   if (CW < 2) begin : g_bad_cw
      $error("pio_cycle_seq: CW must be at least 2");
   end

   // count of N cycles is loaded as N-1, zero counts as one cycle
   function automatic logic [CW-1:0] to_load(input logic [CW-1:0] x);
      return (x == '0) ? '0 : x - 1'b1;
   endfunction

   pio_state_e    state, nxt;
   logic          iordy_s;
   logic          pc_load, pc_dec, pc_zero;
   logic [CW-1:0] pc_val, pc_cnt;

   // per-transfer latched request and timing
   logic          lat_wr, lat_wide, lat_sel, lat_err;
   logic [AW-1:0] lat_addr;
   logic [DW-1:0] lat_wdata;
   logic [CW-1:0] lat_width, lat_hold, lat_recov, lat_cycle, lat_samp, lat_tmo;
   logic [CW-1:0] cyc_cnt, tmo_cnt;

   logic          accept, stall, tmo_fire, cyc_ok, tmo_hit, at_samp;
   logic [CW-1:0] new_width, new_wload, new_samp;
   logic          cur_wr, cur_sel;
   logic [AW-1:0] cur_addr;
   logic [DW-1:0] cur_wdata;
   logic          busy_nxt;

   pio_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rdy_sync (
      .clk(clk), .rst_n(rst_n), .d(ata_iordy), .q(iordy_s)
   );

   pio_down_cnt #(.W(CW)) u_phase (
      .clk(clk), .rst_n(rst_n), .load(pc_load), .load_val(pc_val),
      .dec(pc_dec), .cnt(pc_cnt), .zero(pc_zero)
   );

   // width and clamped ready sample point for an incoming request
   always_comb begin
      new_width = req_wide ? tm_width16 : tm_width8;
      new_wload = to_load(new_width);
      new_samp  = (tm_rdy_setup > new_wload) ? new_wload : tm_rdy_setup;
   end

   assign tmo_hit = (tmo_cnt == lat_tmo);
   assign cyc_ok  = (cyc_cnt >= lat_cycle);
   assign at_samp = (pc_cnt == lat_samp) && !iordy_s;

   always_comb begin
      nxt      = state;
      pc_load  = 1'b0;
      pc_val   = '0;
      pc_dec   = 1'b0;
      accept   = 1'b0;
      stall    = 1'b0;
      tmo_fire = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (req) begin
               accept  = 1'b1;
               nxt     = ST_SETUP;
               pc_load = 1'b1;
               pc_val  = to_load(tm_setup);
            end
         end
         ST_SETUP: begin
            if (pc_zero) begin
               nxt     = ST_STROBE;
               pc_load = 1'b1;
               pc_val  = to_load(lat_width);
            end else begin
               pc_dec = 1'b1;
            end
         end
         ST_STROBE: begin
            if (at_samp) begin
               if (tmo_hit) tmo_fire = 1'b1;
               else         stall    = 1'b1;
            end
            if (!stall) begin
               if (pc_zero) begin
                  nxt     = ST_HOLD;
                  pc_load = 1'b1;
                  pc_val  = to_load(lat_hold);
               end else begin
                  pc_dec = 1'b1;
               end
            end
         end
         ST_HOLD: begin
            if (pc_zero) begin
               nxt     = ST_RECOV;
               pc_load = 1'b1;
               pc_val  = to_load(lat_recov);
            end else begin
               pc_dec = 1'b1;
            end
         end
         ST_RECOV: begin
            if (pc_zero) begin
               if (cyc_ok) nxt = ST_IDLE;
            end else begin
               pc_dec = 1'b1;
            end
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         lat_wr    <= 1'b0;
         lat_wide  <= 1'b0;
         lat_sel   <= 1'b0;
         lat_addr  <= '0;
         lat_wdata <= '0;
         lat_width <= '0;
         lat_hold  <= '0;
         lat_recov <= '0;
         lat_cycle <= '0;
         lat_samp  <= '0;
         lat_tmo   <= '0;
         lat_err   <= 1'b0;
         cyc_cnt   <= '0;
         tmo_cnt   <= '0;
      end else begin
         state <= nxt;
         if (accept) begin
            lat_wr    <= req_write;
            lat_wide  <= req_wide;
            lat_sel   <= req_cs_sel;
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
            lat_width <= new_width;
            lat_hold  <= tm_hold;
            lat_recov <= tm_recov;
            lat_cycle <= tm_cycle;
            lat_samp  <= new_samp;
            lat_tmo   <= tm_rdy_tmo;
            lat_err   <= 1'b0;
            cyc_cnt   <= CNT_ONE;
            tmo_cnt   <= '0;
         end else begin
            if (state != ST_IDLE && cyc_cnt != CNT_MAX) cyc_cnt <= cyc_cnt + 1'b1;
            if (stall)    tmo_cnt <= tmo_cnt + 1'b1;
            if (tmo_fire) lat_err <= 1'b1;
         end
      end
   end

   // request fields in effect for the next registered bus values
   always_comb begin
      cur_wr    = (state == ST_IDLE) ? req_write  : lat_wr;
      cur_sel   = (state == ST_IDLE) ? req_cs_sel : lat_sel;
      cur_addr  = (state == ST_IDLE) ? req_addr   : lat_addr;
      cur_wdata = (state == ST_IDLE) ? req_wdata  : lat_wdata;
      busy_nxt  = (nxt == ST_SETUP) || (nxt == ST_STROBE) || (nxt == ST_HOLD);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ata_addr   <= '0;
         ata_cs_n   <= 2'b11;
         ata_rd_n   <= 1'b1;
         ata_wr_n   <= 1'b1;
         ata_dd_out <= '0;
         ata_dd_oe  <= 1'b0;
         rd_data    <= '0;
         done       <= 1'b0;
         done_err   <= 1'b0;
      end else begin
         if (busy_nxt) ata_addr <= cur_addr;
         ata_cs_n  <= busy_nxt ? (cur_sel ? 2'b01 : 2'b10) : 2'b11;
         ata_rd_n  <= !((nxt == ST_STROBE) && !cur_wr);
         ata_wr_n  <= !((nxt == ST_STROBE) && cur_wr);
         ata_dd_oe <= busy_nxt && cur_wr;
         if (busy_nxt && cur_wr) ata_dd_out <= cur_wdata;
         if (state == ST_STROBE && nxt == ST_HOLD && !lat_wr)
            rd_data <= lat_wide ? ata_dd_in : {{UPPER_W{1'b0}}, ata_dd_in[BYTE_W-1:0]};
         done     <= (state == ST_RECOV) && (nxt == ST_IDLE);
         done_err <= (state == ST_RECOV) && (nxt == ST_IDLE) && lat_err;
      end
   end

   assign ready = (state == ST_IDLE);

   // R7: the host drives the data bus only while no read strobe is active
   p_oe_no_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ata_dd_oe |-> ata_rd_n);
   // R7: never both strobes at once
   p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ata_rd_n && !ata_wr_n));
   // R2: a strobe only appears with exactly one chip select active
   p_strobe_in_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ata_rd_n || !ata_wr_n) |-> ($countones(~ata_cs_n) == 1));
   // R2: address and select steady across the strobe
   p_addr_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((!ata_rd_n || !ata_wr_n) && $past(!ata_rd_n || !ata_wr_n))
         |-> ($stable(ata_addr) && $stable(ata_cs_n)));
   // R12: completion is a single-cycle pulse
   p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R10: the error flag only accompanies completion
   p_err_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_err |-> done);
   // R11: an idle sequencer without a request keeps the bus quiet
   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !req) |=> (ata_cs_n == 2'b11 && ata_rd_n && ata_wr_n && !ata_dd_oe));
endmodule

// File: tb/sim_pio_cycle_seq.sv
module sim_pio_cycle_seq;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 3;
   localparam int DW = 16;
   localparam int CW = 8;

   typedef struct {
      bit          wr;
      bit          wide;
      logic [2:0]  addr;
      bit          sel;
      logic [15:0] wdata;
      logic [15:0] rdata;
      int          setup;
      int          wmin;
      int          wmax;
      int          hold;
      int          busy;
      bit          err;
      string       tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0, req_write = 1'b0, req_wide = 1'b0, req_cs_sel = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [CW-1:0] tm_setup = 8'd3, tm_width16 = 8'd5, tm_width8 = 8'd9, tm_hold = 8'd2;
   logic [CW-1:0] tm_recov = 8'd2, tm_cycle = 8'd0, tm_rdy_setup = 8'd1, tm_rdy_tmo = 8'd6;
   logic ready, done, done_err, ata_rd_n, ata_wr_n, ata_dd_oe;
   logic [DW-1:0] rd_data, ata_dd_out;
   logic [DW-1:0] ata_dd_in = '0;
   logic [AW-1:0] ata_addr;
   logic [1:0] ata_cs_n;
   logic ata_iordy = 1'b1;

   int compared = 0;
   int mismatched = 0;
   bit finished = 0;
   exp_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   pio_cycle_seq #(.AW(AW), .DW(DW), .CW(CW), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write), .req_wide(req_wide),
      .req_addr(req_addr), .req_cs_sel(req_cs_sel), .req_wdata(req_wdata),
      .tm_setup(tm_setup), .tm_width16(tm_width16), .tm_width8(tm_width8),
      .tm_hold(tm_hold), .tm_recov(tm_recov), .tm_cycle(tm_cycle),
      .tm_rdy_setup(tm_rdy_setup), .tm_rdy_tmo(tm_rdy_tmo),
      .ready(ready), .done(done), .done_err(done_err), .rd_data(rd_data),
      .ata_addr(ata_addr), .ata_cs_n(ata_cs_n), .ata_rd_n(ata_rd_n), .ata_wr_n(ata_wr_n),
      .ata_dd_out(ata_dd_out), .ata_dd_oe(ata_dd_oe), .ata_dd_in(ata_dd_in),
      .ata_iordy(ata_iordy)
   );

   task automatic chk(input string tag, input bit ok, input int act, input int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   function automatic int m1(input logic [CW-1:0] x);
      return (x == 0) ? 1 : int'(x);
   endfunction

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   endtask

   // driver: queue the expectation, issue the request, wait for completion
   task automatic xfer(input bit wr, input bit wide, input logic [2:0] a, input bit sel,
                       input logic [15:0] wd, input logic [15:0] din,
                       input int wmin, input int wmax, input int busy, input bit err,
                       input string tag);
      exp_t e;
      e.wr = wr; e.wide = wide; e.addr = a; e.sel = sel; e.wdata = wd;
      e.rdata = wide ? din : {8'h00, din[7:0]};
      e.setup = m1(tm_setup); e.hold = m1(tm_hold);
      e.wmin = wmin; e.wmax = wmax; e.busy = busy; e.err = err; e.tag = tag;
      @(negedge clk);
      while (!ready) @(negedge clk);
      sb.push_back(e);
      ata_dd_in = din;
      req = 1'b1; req_write = wr; req_wide = wide; req_addr = a;
      req_cs_sel = sel; req_wdata = wd;
      @(negedge clk);
      req = 1'b0;
      while (!done) @(negedge clk);
      @(negedge clk);
   endtask

   // monitor
   int busy_c = 0, setup_c = 0, strb_c = 0, hold_c = 0;
   bit seen = 0, bad_oe = 0, bad_wd = 0, bad_addr = 0;
   always @(negedge clk) begin
      if (rst_n && sb.size() > 0) begin
         if (!ready) busy_c++;
         if (!ata_rd_n || !ata_wr_n) begin
            strb_c++;
            seen = 1;
            if (ata_addr != sb[0].addr || ata_cs_n != (sb[0].sel ? 2'b01 : 2'b10)) bad_addr = 1;
            if (sb[0].wr ? ata_wr_n : ata_rd_n) bad_addr = 1;
         end else if (ata_cs_n != 2'b11) begin
            if (!seen) setup_c++;
            else       hold_c++;
         end
         if (ata_dd_oe && !sb[0].wr) bad_oe = 1;
         if (sb[0].wr && ata_cs_n != 2'b11 && (!ata_dd_oe || ata_dd_out != sb[0].wdata)) bad_wd = 1;
         if (done) begin
            exp_t e;
            e = sb.pop_front();
            chk({e.tag, " R2 setup"}, setup_c == e.setup, setup_c, e.setup);
            chk({e.tag, " R2 addr/select"}, !bad_addr, 1, 0);
            chk({e.tag, " R3/R4 strobe width"}, strb_c >= e.wmin && strb_c <= e.wmax, strb_c, e.wmin);
            chk({e.tag, " R5 hold"}, hold_c == e.hold, hold_c, e.hold);
            if (e.busy >= 0) chk({e.tag, " R6 busy cycles"}, busy_c == e.busy, busy_c, e.busy);
            chk({e.tag, " R10 error flag"}, done_err == e.err, done_err, e.err);
            chk({e.tag, " R12 ready with done"}, ready == 1'b1, ready, 1);
            if (e.wr) chk({e.tag, " R7 write drive"}, !bad_wd, 1, 0);
            else begin
               chk({e.tag, " R7 no drive on read"}, !bad_oe, 1, 0);
               chk({e.tag, " R8 read data"}, rd_data == e.rdata, rd_data, e.rdata);
            end
            busy_c = 0; setup_c = 0; strb_c = 0; hold_c = 0;
            seen = 0; bad_oe = 0; bad_wd = 0; bad_addr = 0;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 ready", ready == 1'b1, ready, 1);
      chk("R1 strobes", ata_rd_n && ata_wr_n, {ata_rd_n, ata_wr_n}, 3);
      chk("R1 chip selects", ata_cs_n == 2'b11, ata_cs_n, 3);
      chk("R1 oe/done", !ata_dd_oe && !done && !done_err, {ata_dd_oe, done, done_err}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R3 R7 16-bit write, default timing: 3+5+2+2
      xfer(1, 1, 3'd5, 0, 16'hA55A, 16'h0000, 5, 5, 12, 0, "w16");
      // R3 R8 16-bit read
      xfer(0, 1, 3'd2, 1, 16'h0000, 16'h1234, 5, 5, 12, 0, "r16");
      // R4 8-bit read, upper byte zero
      xfer(0, 0, 3'd7, 0, 16'h0000, 16'hABCD, 9, 9, 16, 0, "r8");
      // R4 8-bit write
      xfer(1, 0, 3'd1, 1, 16'h00C3, 16'h0000, 9, 9, 16, 0, "w8");
      // R6 minimum cycle dominates
      tm_cycle = 8'd30;
      xfer(0, 1, 3'd4, 0, 16'h0000, 16'h5AA5, 5, 5, 30, 0, "cyc");
      tm_cycle = 8'd0;
      // R2 R3 R5 R6 zero counts behave as one cycle
      tm_setup = 0; tm_width16 = 0; tm_hold = 0; tm_recov = 0; tm_rdy_setup = 0;
      xfer(1, 1, 3'd6, 1, 16'h0F0F, 16'h0000, 1, 1, 4, 0, "zero");
      tm_setup = 3; tm_width16 = 5; tm_hold = 2; tm_recov = 2; tm_rdy_setup = 1;

      // R10 stuck ready line: 5 + 6 extension
      ata_iordy = 1'b0;
      repeat (4) @(negedge clk);
      xfer(1, 1, 3'd3, 0, 16'h7E7E, 16'h0000, 11, 11, 18, 1, "tmo");

      // R9 ready released during the stretch
      tm_rdy_tmo = 8'd20;
      fork
         xfer(0, 1, 3'd0, 1, 16'h0000, 16'hC0DE, 6, 24, -1, 0, "stretch");
         begin
            @(negedge clk);
            while (ata_rd_n) @(negedge clk);
            repeat (7) @(negedge clk);
            ata_iordy = 1'b1;
         end
      join
      tm_rdy_tmo = 8'd6;
      repeat (3) @(negedge clk);

      // R11 request and timing change while busy are ignored
      fork
         xfer(1, 1, 3'd2, 0, 16'h1111, 16'h0000, 5, 5, 12, 0, "busyreq");
         begin
            repeat (3) @(negedge clk);
            tm_width16 = 8'd2;
            req = 1'b1; req_write = 1'b0; req_addr = 3'd7; req_cs_sel = 1'b1;
            repeat (3) @(negedge clk);
            req = 1'b0;
         end
      join
      tm_width16 = 8'd5;
      begin
         bit quiet;
         quiet = 1;
         for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (!ready || !ata_rd_n || !ata_wr_n || ata_cs_n != 2'b11) quiet = 0;
         end
         chk("R11 no extra transfer", quiet, quiet, 1);
      end
      chk("R11 queue drained", sb.size() == 0, sb.size(), 0);
      finish_run();
   end
endmodule